// File: doc/BRIEF.md
# Offload Issue Controller

This block sits inside a processor core and drives the initiator side of a request channel toward attached accelerators. When the core's own decoder hands over an instruction it cannot execute, the controller registers it and raises a request valid. The instruction stays unchanged until the target returns ready. In the cycle of that handshake, the target also reports whether it accepts the instruction and which of the three source operands it reads. A 16-bit compressed encoding is sent as it is, not expanded, in the low half of the word, and the upper bits are cleared.

A rejected instruction produces a one-cycle illegal-instruction pulse. An accepted instruction is followed by operand delivery. The controller holds the issuing pipeline stage only while an operand that the target actually reads still has a pending register hazard. Hazards on operands that the target does not read are ignored.

Two compile-time options set the register-file side. The first decides whether a third read port exists for operand C. The second decides whether a result may be written to an even destination register and the register after it in the same cycle, over a result path of double width.

Top module: `offload_issue_ctrl`

## Requirements
- R1: After reset, `req_valid_o`, `stall_o`, `illegal_o`, `opnd_valid_o` and both write enables are low.
- R2: An offload is taken in a cycle where `dec_offload_i` is high and `stall_o` is low. In the next cycle `req_valid_o` is high. If the instruction has bits [1:0] equal to 2'b11, `req_instr_o` carries it unchanged.
- R3: An instruction whose bits [1:0] are not 2'b11 is compressed. It is presented with bits [15:0] kept and every higher bit driven to zero.
- R4: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o` stays high, `req_instr_o` stays stable and `stall_o` is high.
- R5: A transfer completes in a cycle with `req_valid_o` and `req_ready_i` both high. In the following cycle `req_valid_o` is low, unless a new offload was taken in the handshake cycle. In that case `req_valid_o` stays high and the new instruction is presented.
- R6: If `req_accept_i` is low in the handshake cycle, `illegal_o` is high for exactly that cycle and `opnd_valid_o` stays low.
- R7: `req_use_i` bit 0, 1 and 2 mark operands A, B and C as read. It is sampled in an accepted handshake. If no read operand has its `rs_busy_i` bit set, `opnd_valid_o` pulses in the handshake cycle. Otherwise `stall_o` stays high and `opnd_valid_o` low until those busy bits clear, and `opnd_valid_o` then pulses in that cycle. Busy bits of operands that are not read cause no stall.
- R8: When `opnd_valid_o` is high, each operand output equals its register value if it is read and zero if it is not.
- R9: With the third read port disabled, `opnd_c_o` is always zero and the operand C use and busy bits have no effect on stalling.
- R10: With dual writeback enabled, a result with `res_dual_i` high and an even, nonzero `res_rd_i` writes `res_rd_i` with the low half and `res_rd_i`+1 with the high half in the same cycle. For an odd or zero destination only write port 0 is enabled.
- R11: With dual writeback disabled, write port 1 is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_offload_i | input | 1 | Decoder requests offload of `dec_instr_i` |
| dec_instr_i | input | ILEN | Instruction word from the decoder |
| rs1_data_i | input | XLEN | Register value for operand A |
| rs2_data_i | input | XLEN | Register value for operand B |
| rs3_data_i | input | XLEN | Register value for operand C |
| rs_busy_i | input | 3 | Per-operand pending-hazard flags (bit 0 = A) |
| req_valid_o | output | 1 | Request channel valid |
| req_instr_o | output | ILEN | Request channel instruction |
| req_ready_i | input | 1 | Request channel ready |
| req_accept_i | input | 1 | Target accepts the instruction (valid with ready) |
| req_use_i | input | 3 | Target reads operands A/B/C (valid with ready) |
| opnd_valid_o | output | 1 | Operands delivered this cycle |
| opnd_a_o | output | XLEN | Operand A |
| opnd_b_o | output | XLEN | Operand B |
| opnd_c_o | output | XLEN | Operand C |
| stall_o | output | 1 | Hold the issuing pipeline stage |
| illegal_o | output | 1 | Illegal-instruction pulse |
| res_valid_i | input | 1 | Result available |
| res_rd_i | input | RF_AW | Result destination register |
| res_dual_i | input | 1 | Result asks for a paired writeback |
| res_data_i | input | 2*XLEN | Result data, low half first |
| rf_we_o | output | 2 | Register-file write enables, ports 0 and 1 |
| rf_waddr0_o | output | RF_AW | Write port 0 address |
| rf_waddr1_o | output | RF_AW | Write port 1 address |
| rf_wdata0_o | output | XLEN | Write port 0 data |
| rf_wdata1_o | output | XLEN | Write port 1 data |

## Verification
The bench holds ready low for several cycles. A design that let valid drop or the word change during backpressure would lose or corrupt the request. A rejection is issued in the same cycle as a new offload, so a controller that always dropped valid after a handshake would present an idle gap, or the wrong word, to the scoreboard. The bench places hazards on operands the target does not read, where a pessimistic design would stall without cause, and a hazard on a read operand, where a careless design would deliver a stale value early. Writebacks to an odd register and to x0 with the dual flag set, plus a second instance with both options disabled, catch a paired write that should never happen.

// File: rtl/offload_pkg.sv
package offload_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_OPND = 2'd2
   } iss_state_e;

   localparam int unsigned NUM_OPND   = 3;
   localparam int unsigned HALF_ILEN  = 16;
   localparam logic [1:0]  FULL_LOW2  = 2'b11;
endpackage

// File: rtl/offload_opnd_gate.sv
module offload_opnd_gate
   import offload_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter bit          HAS_C  = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sel_live_i,
   input  logic [NUM_OPND-1:0] use_live_i,
   input  logic [NUM_OPND-1:0] use_held_i,
   input  logic [NUM_OPND-1:0] busy_i,
   input  logic [XLEN-1:0]     rs1_i,
   input  logic [XLEN-1:0]     rs2_i,
   input  logic [XLEN-1:0]     rs3_i,
   input  logic                fire_i,
   output logic [NUM_OPND-1:0] use_eff_o,
   output logic                blocked_o,
   output logic [XLEN-1:0]     a_o,
   output logic [XLEN-1:0]     b_o,
   output logic [XLEN-1:0]     c_o
);
   logic [NUM_OPND-1:0] use_sel;
   logic [NUM_OPND-1:0] port_mask;

   assign use_sel = sel_live_i ? use_live_i : use_held_i;

   generate
      if (HAS_C) begin : g_three_port
         assign port_mask = {NUM_OPND{1'b1}};
         assign c_o       = use_eff_o[2] ? rs3_i : '0;
      end else begin : g_two_port
         assign port_mask = {1'b0, {(NUM_OPND-1){1'b1}}};
         assign c_o       = '0;
         p_c_tied_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fire_i |-> (c_o == '0));
      end
   endgenerate

   assign use_eff_o = use_sel & port_mask;
   assign blocked_o = |(use_eff_o & busy_i);
   assign a_o       = use_eff_o[0] ? rs1_i : '0;
   assign b_o       = use_eff_o[1] ? rs2_i : '0;

   // R7: delivery never coincides with a hazard on a read operand
   p_no_fire_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |-> ((use_eff_o & busy_i) == '0));
endmodule

// File: rtl/offload_wb_map.sv
module offload_wb_map #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned RF_AW   = 5,
   parameter bit          DUAL_WB = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              res_valid_i,
   input  logic [RF_AW-1:0]  res_rd_i,
   input  logic              res_dual_i,
   input  logic [2*XLEN-1:0] res_data_i,
   output logic [1:0]        we_o,
   output logic [RF_AW-1:0]  waddr0_o,
   output logic [RF_AW-1:0]  waddr1_o,
   output logic [XLEN-1:0]   wdata0_o,
   output logic [XLEN-1:0]   wdata1_o
);
   assign we_o[0]  = res_valid_i;
   assign waddr0_o = res_rd_i;
   assign wdata0_o = res_data_i[XLEN-1:0];

   generate
      if (DUAL_WB) begin : g_dual
         logic pair_ok;
         assign pair_ok  = res_dual_i && !res_rd_i[0] && (res_rd_i != '0);
         assign we_o[1]  = res_valid_i && pair_ok;
         assign waddr1_o = res_rd_i | RF_AW'(1);
         assign wdata1_o = res_data_i[2*XLEN-1:XLEN];

         // R10: the second write always targets the register above the first
         p_pair_adjacent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            we_o[1] |-> (we_o[0] && (waddr1_o == waddr0_o + RF_AW'(1))));
      end else begin : g_single
         assign we_o[1]  = 1'b0;
         assign waddr1_o = '0;
         assign wdata1_o = '0;
      end
   endgenerate
endmodule

// File: rtl/offload_req_fsm.sv
module offload_req_fsm
   import offload_pkg::*;
#(
   parameter int unsigned ILEN = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                dec_offload_i,
   input  logic [ILEN-1:0]     dec_instr_i,
   input  logic                ready_i,
   input  logic                accept_i,
   input  logic [NUM_OPND-1:0] use_eff_i,
   input  logic                blocked_i,
   output logic                valid_o,
   output logic [ILEN-1:0]     instr_o,
   output logic                sel_live_o,
   output logic [NUM_OPND-1:0] use_held_o,
   output logic                fire_o,
   output logic                stall_o,
   output logic                illegal_o
);
   iss_state_e          state_q, state_d;
   logic [ILEN-1:0]     instr_q;
   logic [NUM_OPND-1:0] use_q;
   logic                hs, take, in_req, in_opnd;
   logic [ILEN-1:0]     instr_fmt;

   assign in_req  = (state_q == ST_REQ);
   assign in_opnd = (state_q == ST_OPND);
   assign hs      = in_req && ready_i;

   always_comb begin
      if (dec_instr_i[1:0] != FULL_LOW2)
         instr_fmt = {{(ILEN-HALF_ILEN){1'b0}}, dec_instr_i[HALF_ILEN-1:0]};
      else
         instr_fmt = dec_instr_i;
   end

   assign stall_o   = (in_req && !(ready_i && (!accept_i || !blocked_i)))
                    || (in_opnd && blocked_i);
   assign take      = dec_offload_i && !stall_o;
   assign illegal_o = hs && !accept_i;
   assign fire_o    = (hs && accept_i && !blocked_i) || (in_opnd && !blocked_i);

   always_comb begin
      state_d = state_q;
      if (take)
         state_d = ST_REQ;
      else if (hs)
         state_d = (accept_i && blocked_i) ? ST_OPND : ST_IDLE;
      else if (in_opnd && !blocked_i)
         state_d = ST_IDLE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         instr_q <= '0;
         use_q   <= '0;
      end else begin
         state_q <= state_d;
         if (take)
            instr_q <= instr_fmt;
         if (hs && accept_i && blocked_i)
            use_q <= use_eff_i;
      end
   end

   assign valid_o    = in_req;
   assign instr_o    = instr_q;
   assign sel_live_o = in_req;
   assign use_held_o = use_q;

   // R4: held request stays put under backpressure
   p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !ready_i) |=> (valid_o && $stable(instr_o)));
   p_stall_bp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !ready_i) |-> stall_o);
   // R5: valid falls after a completed transfer unless a new offload was taken
   p_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && ready_i && !dec_offload_i) |=> !valid_o);
   // R6: a rejected instruction never delivers operands
   p_illegal_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> (!fire_o && valid_o));
endmodule

// File: rtl/offload_issue_ctrl.sv
module offload_issue_ctrl
   import offload_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned ILEN     = 32,
   parameter int unsigned RF_AW    = 5,
   parameter bit          HAS_RS3  = 1'b1,
   parameter bit          DUAL_WB  = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                dec_offload_i,
   input  logic [ILEN-1:0]     dec_instr_i,
   input  logic [XLEN-1:0]     rs1_data_i,
   input  logic [XLEN-1:0]     rs2_data_i,
   input  logic [XLEN-1:0]     rs3_data_i,
   input  logic [2:0]          rs_busy_i,
   output logic                req_valid_o,
   output logic [ILEN-1:0]     req_instr_o,
   input  logic                req_ready_i,
   input  logic                req_accept_i,
   input  logic [2:0]          req_use_i,
   output logic                opnd_valid_o,
   output logic [XLEN-1:0]     opnd_a_o,
   output logic [XLEN-1:0]     opnd_b_o,
   output logic [XLEN-1:0]     opnd_c_o,
   output logic                stall_o,
   output logic                illegal_o,
   input  logic                res_valid_i,
   input  logic [RF_AW-1:0]    res_rd_i,
   input  logic                res_dual_i,
   input  logic [2*XLEN-1:0]   res_data_i,
   output logic [1:0]          rf_we_o,
   output logic [RF_AW-1:0]    rf_waddr0_o,
   output logic [RF_AW-1:0]    rf_waddr1_o,
   output logic [XLEN-1:0]     rf_wdata0_o,
   output logic [XLEN-1:0]     rf_wdata1_o
);
   generate
      if (ILEN < 2*HALF_ILEN) begin : g_bad_ilen
         $error("ILEN must hold a full-length instruction");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN too small");
      end
      if (RF_AW < 2) begin : g_bad_aw
         $error("RF_AW too small for paired writeback");
      end
   endgenerate

   logic [NUM_OPND-1:0] use_eff, use_held;
   logic                blocked, sel_live, fire;

   offload_req_fsm #(.ILEN(ILEN)) u_fsm (
      .clk_i, .rst_ni,
      .dec_offload_i, .dec_instr_i,
      .ready_i    (req_ready_i),
      .accept_i   (req_accept_i),
      .use_eff_i  (use_eff),
      .blocked_i  (blocked),
      .valid_o    (req_valid_o),
      .instr_o    (req_instr_o),
      .sel_live_o (sel_live),
      .use_held_o (use_held),
      .fire_o     (fire),
      .stall_o    (stall_o),
      .illegal_o  (illegal_o)
   );

   offload_opnd_gate #(.XLEN(XLEN), .HAS_C(HAS_RS3)) u_gate (
      .clk_i, .rst_ni,
      .sel_live_i (sel_live),
      .use_live_i (req_use_i),
      .use_held_i (use_held),
      .busy_i     (rs_busy_i),
      .rs1_i      (rs1_data_i),
      .rs2_i      (rs2_data_i),
      .rs3_i      (rs3_data_i),
      .fire_i     (fire),
      .use_eff_o  (use_eff),
      .blocked_o  (blocked),
      .a_o        (opnd_a_o),
      .b_o        (opnd_b_o),
      .c_o        (opnd_c_o)
   );

   offload_wb_map #(.XLEN(XLEN), .RF_AW(RF_AW), .DUAL_WB(DUAL_WB)) u_wb (
      .clk_i, .rst_ni,
      .res_valid_i, .res_rd_i, .res_dual_i, .res_data_i,
      .we_o     (rf_we_o),
      .waddr0_o (rf_waddr0_o),
      .waddr1_o (rf_waddr1_o),
      .wdata0_o (rf_wdata0_o),
      .wdata1_o (rf_wdata1_o)
   );

   assign opnd_valid_o = fire;

   // R11: no paired write when the option is off
   p_single_wb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !DUAL_WB |-> !rf_we_o[1]);
endmodule

// File: tb/offload_issue_ctrl_tb_top.sv
module offload_issue_ctrl_tb_top;
   localparam int unsigned XLEN = 32;
   localparam int unsigned ILEN = 32;
   localparam int unsigned AW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            dec_offload = 1'b0;
   logic [ILEN-1:0] dec_instr = '0;
   logic [XLEN-1:0] rs1 = 32'h1111_0001, rs2 = 32'h2222_0002, rs3 = 32'h3333_0003;
   logic [2:0]      busy = '0;
   logic            ready = 1'b0, accept = 1'b0;
   logic [2:0]      use_f = '0;
   logic            res_valid = 1'b0, res_dual = 1'b0;
   logic [AW-1:0]   res_rd = '0;
   logic [2*XLEN-1:0] res_data = '0;

   logic            req_valid, stall, illegal, opnd_valid;
   logic [ILEN-1:0] req_instr;
   logic [XLEN-1:0] oa, ob, oc, wd0, wd1;
   logic [1:0]      we;
   logic [AW-1:0]   wa0, wa1;

   logic            m_req_valid, m_stall, m_illegal, m_opnd_valid;
   logic [ILEN-1:0] m_req_instr;
   logic [XLEN-1:0] m_oa, m_ob, m_oc, m_wd0, m_wd1;
   logic [1:0]      m_we;
   logic [AW-1:0]   m_wa0, m_wa1;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [ILEN-1:0] exp_q[$];

   always #4 clk = ~clk;

   offload_issue_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .dec_offload_i(dec_offload), .dec_instr_i(dec_instr),
      .rs1_data_i(rs1), .rs2_data_i(rs2), .rs3_data_i(rs3), .rs_busy_i(busy),
      .req_valid_o(req_valid), .req_instr_o(req_instr), .req_ready_i(ready),
      .req_accept_i(accept), .req_use_i(use_f), .opnd_valid_o(opnd_valid),
      .opnd_a_o(oa), .opnd_b_o(ob), .opnd_c_o(oc), .stall_o(stall), .illegal_o(illegal),
      .res_valid_i(res_valid), .res_rd_i(res_rd), .res_dual_i(res_dual), .res_data_i(res_data),
      .rf_we_o(we), .rf_waddr0_o(wa0), .rf_waddr1_o(wa1), .rf_wdata0_o(wd0), .rf_wdata1_o(wd1));

   offload_issue_ctrl #(.HAS_RS3(1'b0), .DUAL_WB(1'b0)) dut_min_i (
      .clk_i(clk), .rst_ni(rst_n), .dec_offload_i(dec_offload), .dec_instr_i(dec_instr),
      .rs1_data_i(rs1), .rs2_data_i(rs2), .rs3_data_i(rs3), .rs_busy_i(busy),
      .req_valid_o(m_req_valid), .req_instr_o(m_req_instr), .req_ready_i(ready),
      .req_accept_i(accept), .req_use_i(use_f), .opnd_valid_o(m_opnd_valid),
      .opnd_a_o(m_oa), .opnd_b_o(m_ob), .opnd_c_o(m_oc), .stall_o(m_stall), .illegal_o(m_illegal),
      .res_valid_i(res_valid), .res_rd_i(res_rd), .res_dual_i(res_dual), .res_data_i(res_data),
      .rf_we_o(m_we), .rf_waddr0_o(m_wa0), .rf_waddr1_o(m_wa1), .rf_wdata0_o(m_wd0), .rf_wdata1_o(m_wd1));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every completed transfer must match the next queued word
   always @(negedge clk) begin
      if (rst_n && req_valid && ready) begin
         if (exp_q.size() == 0) chk("R2 unexpected transfer", 64'(req_instr), 64'hDEAD);
         else chk("R2/R3 scoreboard word", 64'(req_instr), 64'(exp_q.pop_front()));
      end
   end

   function automatic logic [ILEN-1:0] fmt(input logic [ILEN-1:0] w);
      return (w[1:0] != 2'b11) ? {16'h0, w[15:0]} : w;
   endfunction

   task automatic issue(input logic [ILEN-1:0] w);
      @(negedge clk);
      while (stall) @(negedge clk);
      dec_offload = 1'b1;
      dec_instr   = w;
      exp_q.push_back(fmt(w));
      @(posedge clk); #1;
      dec_offload = 1'b0;
   endtask

   task automatic target(input logic rdy, input logic acc, input logic [2:0] u);
      ready = rdy; accept = acc; use_f = u;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 valid", 64'(req_valid), 0);
      chk("R1 stall", 64'(stall), 0);
      chk("R1 illegal", 64'(illegal), 0);
      chk("R1 opnd_valid", 64'(opnd_valid), 0);
      chk("R1 we", 64'(we), 0);

      // R2 full-length word, R4 backpressure
      issue(32'h00C5_8533);
      @(negedge clk);
      chk("R2 valid", 64'(req_valid), 1);
      chk("R2 word", 64'(req_instr), 64'h00C5_8533);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R4 valid held", 64'(req_valid), 1);
         chk("R4 word stable", 64'(req_instr), 64'h00C5_8533);
         chk("R4 stall", 64'(stall), 1);
      end
      @(posedge clk); #1 target(1, 1, 3'b011);
      @(negedge clk);
      chk("R7 immediate opnd_valid", 64'(opnd_valid), 1);
      chk("R8 opnd a", 64'(oa), 64'(rs1));
      chk("R8 opnd b", 64'(ob), 64'(rs2));
      chk("R8 opnd c unused", 64'(oc), 0);
      chk("R6 no illegal on accept", 64'(illegal), 0);
      @(posedge clk); #1 target(0, 0, 0);
      @(negedge clk);
      chk("R5 valid drops", 64'(req_valid), 0);

      // R3 compressed word, R6 reject
      issue(32'hABCD_4501);
      @(negedge clk);
      chk("R3 zeroed upper half", 64'(req_instr), 64'h0000_4501);
      @(posedge clk); #1 target(1, 0, 3'b111);
      @(negedge clk);
      chk("R6 illegal pulse", 64'(illegal), 1);
      chk("R6 no operands", 64'(opnd_valid), 0);
      @(posedge clk); #1 target(0, 0, 0);
      @(negedge clk);
      chk("R6 pulse ends", 64'(illegal), 0);
      chk("R5 idle after reject", 64'(req_valid), 0);

      // R5 back-to-back: reject with a new offload in the same cycle
      issue(32'h0000_0013);
      @(posedge clk); #1 target(1, 0, 0);
      dec_offload = 1'b1; dec_instr = 32'h1234_5677;
      exp_q.push_back(32'h1234_5677);
      @(negedge clk);
      chk("R5 no stall in reject cycle", 64'(stall), 0);
      @(posedge clk); #1 target(0, 0, 0); dec_offload = 1'b0;
      @(negedge clk);
      chk("R5 valid kept for next", 64'(req_valid), 1);
      chk("R5 next word", 64'(req_instr), 64'h1234_5677);
      @(posedge clk); #1 target(1, 1, 3'b000);
      @(negedge clk);
      chk("R7 no operands read fires", 64'(opnd_valid), 1);
      @(posedge clk); #1 target(0, 0, 0);

      // R7 busy on an unread operand is ignored
      issue(32'h0000_0033);
      @(posedge clk); #1 target(1, 1, 3'b001); busy = 3'b010;
      @(negedge clk);
      chk("R7 unread busy no stall", 64'(stall), 0);
      chk("R7 unread busy fires", 64'(opnd_valid), 1);
      @(posedge clk); #1 target(0, 0, 0); busy = 3'b000;

      // R7 busy on a read operand waits; R9 on the reduced instance
      issue(32'h0000_00B3);
      @(posedge clk); #1 target(1, 1, 3'b100); busy = 3'b100;
      @(negedge clk);
      chk("R7 read busy stalls", 64'(stall), 1);
      chk("R7 read busy holds", 64'(opnd_valid), 0);
      chk("R9 no port C no stall", 64'(m_stall), 0);
      chk("R9 no port C fires", 64'(m_opnd_valid), 1);
      chk("R9 c tied", 64'(m_oc), 0);
      @(posedge clk); #1 target(0, 0, 0);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk("R7 wait stall", 64'(stall), 1);
         chk("R7 wait no fire", 64'(opnd_valid), 0);
      end
      @(posedge clk); #1 busy = 3'b000;
      @(negedge clk);
      chk("R7 release fires", 64'(opnd_valid), 1);
      chk("R8 opnd c", 64'(oc), 64'(rs3));
      chk("R8 opnd a unused", 64'(oa), 0);
      chk("R7 release no stall", 64'(stall), 0);
      @(posedge clk); #1;
      @(negedge clk);
      chk("R7 idle after release", 64'(req_valid), 0);

      // R10 / R11 writeback
      res_valid = 1'b1; res_dual = 1'b1; res_rd = 5'd4;
      res_data = {32'hBBBB_0002, 32'hAAAA_0001};
      @(negedge clk);
      chk("R10 pair we", 64'(we), 2'b11);
      chk("R10 addr0", 64'(wa0), 4);
      chk("R10 addr1", 64'(wa1), 5);
      chk("R10 data0", 64'(wd0), 64'hAAAA_0001);
      chk("R10 data1", 64'(wd1), 64'hBBBB_0002);
      chk("R11 single only", 64'(m_we), 2'b01);
      res_rd = 5'd5;
      @(negedge clk);
      chk("R10 odd rd single", 64'(we), 2'b01);
      res_rd = 5'd0;
      @(negedge clk);
      chk("R10 x0 single", 64'(we), 2'b01);
      res_valid = 1'b0; res_dual = 1'b0;

      @(negedge clk);
      chk("R2 scoreboard drained", 64'(exp_q.size()), 0);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule